// File: doc/BRIEF.md
# Parallel Port Pattern Match Unit

This block watches a parallel input port and decides on every clock whether the sampled value meets a condition that software has programmed. Three per-bit control vectors give each port line one of six conditions: don't care, steady low, steady high, rising edge, falling edge or either edge. A 2-bit mode then folds the per-line results into one match. The match can be turned off, combined as an AND, combined as an OR, or combined as a level-sensitive OR that also reports which line matched.

The block keeps a sticky pattern-match flag and an interrupt-pending bit, and it raises an interrupt request when that bit is set and interrupts are enabled. Software acknowledges a match with a clear pulse. Normally any change on the sampled port also marks an interrupt as pending. A match-only control restricts the pending bit to pattern matches.

In latched mode the port value that caused a match is frozen on the data output until software clears it. In transparent mode the data output follows the sampled port.

Top module: `pattern_match_unit`

## Requirements
- R1: While reset is held and after it is released, `match_flag`, `ip`, `irq`, `vec_idx` and `data_out` are all zero.
- R2: The port is registered once; an edge is the difference between the two most recent samples. The per-line condition is selected by {`mask_bits[i]`,`edge_bits[i]`}. The value 00 is don't care. The value 01 is either edge. The value 10 needs the line to equal `pol_bits[i]`. The value 11 needs a rising edge when `pol_bits[i]`=1 and a falling edge when it is 0. A line is active when either its mask bit or its edge bit is 1.
- R3: In `mode`=01 (AND) the combined match is true when every active line meets its condition and at least one line is active. On the clock where the combined match changes from false to true, `match_flag` and `ip` are set. This is two clock edges after the port change that completes the match, and the setting happens once for each rising of the match.
- R4: In `mode`=10 (OR) the combined match is true when any active line meets its condition. The flag and pending bit are set as in R3.
- R5: In `mode`=11 (level OR) the combined match is the same as in R4. `match_flag` follows the match one clock later, and `ip` is set on every clock that the match holds. `vec_idx` holds the index of the highest-numbered matching line while the match holds, and zero otherwise.
- R6: In `mode`=00 nothing matches and `match_flag` is zero one clock later.
- R7: A `clr_ip` pulse clears `match_flag` (in modes 01 and 10) and `ip`. When a set and a clear fall in the same clock, the set wins.
- R8: When `match_only`=0, any difference between the two latest port samples sets `ip` without setting `match_flag`. When `match_only`=1, a port change without a match leaves `ip` unchanged.
- R9: `irq` is `ip` gated by `irq_en`.
- R10: When `latched_mode`=0, `data_out` is the port sampled one clock earlier. When `latched_mode`=1, a match event captures the matching sample, and `data_out` holds that sample until a `clr_ip` pulse. Events that occur while a sample is held do not replace it.
- R11: Level mode is valid only in transparent mode. With `latched_mode`=1 and `mode`=11, nothing matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_in | input | WIDTH | Parallel port lines |
| mode | input | 2 | Combine mode: 00 off, 01 AND, 10 OR, 11 level OR with index |
| latched_mode | input | 1 | 1 = freeze the matching sample on `data_out` |
| pol_bits | input | WIDTH | Per-line level or edge direction |
| edge_bits | input | WIDTH | Per-line edge selection |
| mask_bits | input | WIDTH | Per-line level/directed-edge enable |
| match_only | input | 1 | 1 = only pattern matches set `ip` |
| irq_en | input | 1 | Interrupt enable |
| clr_ip | input | 1 | Clear pending bit, flag and held sample |
| data_out | output | WIDTH | Sampled or frozen port value |
| match_flag | output | 1 | Pattern match detected |
| ip | output | 1 | Interrupt pending |
| irq | output | 1 | Interrupt request |
| vec_idx | output | $clog2(WIDTH) | Highest matching line in level mode |

## Verification
There are two ways an internal error can surface. If the stored previous sample or the previous match state is wrong, edges are found on the wrong clock, so `match_flag` and `ip` rise a clock early, a clock late or twice. A per-clock comparison against a behavioural model catches this on the clock that follows the faulty state. A stuck freeze register shows on `data_out` within one clock: the output either fails to follow the port, or it does not release after `clr_ip`. Directed sequences fix the expected clock of each event, and random configurations cover the six line conditions in every mode.

// File: rtl/pattern_match_unit.sv
module pattern_match_unit #(
  parameter int WIDTH = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [WIDTH-1:0]                     port_in,
  input  logic [1:0]                           mode,
  input  logic                                 latched_mode,
  input  logic [WIDTH-1:0]                     pol_bits,
  input  logic [WIDTH-1:0]                     edge_bits,
  input  logic [WIDTH-1:0]                     mask_bits,
  input  logic                                 match_only,
  input  logic                                 irq_en,
  input  logic                                 clr_ip,
  output logic [WIDTH-1:0]                     data_out,
  output logic                                 match_flag,
  output logic                                 ip,
  output logic                                 irq,
  output logic [((WIDTH>1)?$clog2(WIDTH):1)-1:0] vec_idx
);
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [1:0] M_OFF = 2'b00, M_AND = 2'b01, M_OR = 2'b10, M_LVL = 2'b11;

  logic [WIDTH-1:0] cur_q, prev_q, hold_q, hit, active;
  logic             match_q, frozen_q;
  logic             all_ok, match_c, lvl, evt, chg;
  logic [IW-1:0]    idx_c;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      cur_q  <= port_in;
      prev_q <= cur_q;
    end

  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic rise, fall;
    assign rise = cur_q[g] & ~prev_q[g];
    assign fall = ~cur_q[g] & prev_q[g];
    always_comb
      case ({mask_bits[g], edge_bits[g]})
        2'b00:   hit[g] = 1'b0;
        2'b01:   hit[g] = rise | fall;
        2'b10:   hit[g] = (cur_q[g] == pol_bits[g]);
        default: hit[g] = pol_bits[g] ? rise : fall;
      endcase
  end

  assign active = mask_bits | edge_bits;
  assign all_ok = &(hit | ~active);
  assign lvl    = (mode == M_LVL);
  assign chg    = (cur_q != prev_q);

  always_comb
    case (mode)
      M_AND:   match_c = all_ok & (|active);
      M_OR:    match_c = |hit;
      M_LVL:   match_c = ~latched_mode & (|hit);
      default: match_c = 1'b0;
    endcase

  always_comb begin
    idx_c = '0;
    for (int i = 0; i < WIDTH; i++)
      if (hit[i]) idx_c = IW'(i);
  end

  assign evt = ~lvl & match_c & ~match_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      match_q    <= 1'b0;
      match_flag <= 1'b0;
      ip         <= 1'b0;
      vec_idx    <= '0;
    end else begin
      match_q <= match_c;
      if (mode == M_OFF)  match_flag <= 1'b0;
      else if (lvl)       match_flag <= match_c;
      else                match_flag <= (match_flag & ~clr_ip) | evt;
      ip      <= (ip & ~clr_ip) | evt | (lvl & match_c) | (~match_only & chg);
      vec_idx <= (lvl & match_c) ? idx_c : '0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      frozen_q <= 1'b0;
      hold_q   <= '0;
    end else if (!latched_mode) begin
      frozen_q <= 1'b0;
    end else if (evt && !frozen_q) begin
      frozen_q <= 1'b1;
      hold_q   <= cur_q;
    end else if (clr_ip) begin
      frozen_q <= 1'b0;
    end

  assign data_out = frozen_q ? hold_q : cur_q;
  assign irq      = ip & irq_en;

  a_r6_off_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_OFF) |=> !match_flag);
  a_r11_latched_level_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_mode && mode == M_LVL) |=> !match_flag);
  a_r5_vec_implies_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_idx != '0) |-> match_flag);
  a_r3_flag_rise_sets_ip: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_flag) |-> ip);
  a_r10_frozen_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen_q && $past(frozen_q)) |-> (data_out == $past(data_out)));
endmodule

// File: tb/pattern_match_unit_tb.sv
`timescale 1ns/1ps
module pattern_match_unit_tb;
  localparam int W = 8;
  logic clk = 0, rst_n = 0;
  logic [W-1:0] port_in = 0, pol = 0, edg = 0, msk = 0;
  logic [1:0] mode = 0;
  logic latched = 0, monly = 1, irq_en = 0, clr = 0;
  logic [W-1:0] data_out;
  logic flag, ip, irq;
  logic [2:0] vec;
  int total = 0, bad = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  pattern_match_unit #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .port_in(port_in), .mode(mode), .latched_mode(latched),
    .pol_bits(pol), .edge_bits(edg), .mask_bits(msk), .match_only(monly), .irq_en(irq_en),
    .clr_ip(clr), .data_out(data_out), .match_flag(flag), .ip(ip), .irq(irq), .vec_idx(vec));

  int m_cur, m_prev, m_hold, m_vec;
  bit m_match, m_flag, m_ip, m_frozen;

  function automatic void eval(input int c, input int p, output bit mt, output int vi);
    bit all = 1, anyact = 0, anyhit = 0;
    vi = 0;
    for (int i = 0; i < W; i++) begin
      bit ci = c[i], pi = p[i], ok = 0;
      if (!msk[i]) ok = edg[i] ? (ci != pi) : 0;
      else if (!edg[i]) ok = (ci == pol[i]);
      else ok = pol[i] ? (ci && !pi) : (!ci && pi);
      if (msk[i] || edg[i]) begin
        anyact = 1;
        if (!ok) all = 0;
        if (ok) begin anyhit = 1; vi = i; end
      end
    end
    case (mode)
      2'b01: mt = all && anyact;
      2'b10: mt = anyhit;
      2'b11: mt = !latched && anyhit;
      default: mt = 0;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cur = 0; m_prev = 0; m_hold = 0; m_vec = 0;
      m_match = 0; m_flag = 0; m_ip = 0; m_frozen = 0;
    end else begin
      bit mc, lv, ev, ch; int vi;
      eval(m_cur, m_prev, mc, vi);
      lv = (mode == 2'b11);
      ev = !lv && mc && !m_match;
      ch = (m_cur != m_prev);
      if (mode == 0) m_flag = 0;
      else if (lv) m_flag = mc;
      else m_flag = (m_flag && !clr) || ev;
      m_ip = (m_ip && !clr) || ev || (lv && mc) || (!monly && ch);
      m_vec = (lv && mc) ? vi : 0;
      if (!latched) m_frozen = 0;
      else if (ev && !m_frozen) begin m_frozen = 1; m_hold = m_cur; end
      else if (clr) m_frozen = 0;
      m_match = mc; m_prev = m_cur; m_cur = port_in;
    end
    #1;
    if (!done) begin
      chk(cur_req, flag, m_flag, "flag");
      chk(cur_req, ip, m_ip, "ip");
      chk(cur_req, irq, m_ip && irq_en, "irq");
      chk(cur_req, vec, m_vec, "vec");
      chk(cur_req, data_out, m_frozen ? m_hold : m_cur, "data_out");
    end
  end

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask
  task automatic pulse_clr; @(negedge clk); clr = 1; @(negedge clk); clr = 0; endtask
  task automatic probe; @(posedge clk); #1.5; endtask

  initial begin
    cyc(3);
    #1 chk("R1", {flag, ip, irq, vec, data_out}, 0, "reset outputs");
    @(negedge clk); rst_n = 1;
    probe(); chk("R1", {flag, ip, irq, vec, data_out}, 0, "after release");

    cur_req = "R3";
    @(negedge clk); mode = 2'b01; msk = 8'h0F; edg = 8'h01; pol = 8'h07; irq_en = 1; port_in = 8'h06;
    cyc(3); port_in = 8'h07;
    probe(); chk("R3", flag, 0, "flag one edge after change");
    probe(); chk("R3", flag, 1, "AND match flag");
    chk("R9", irq, 1, "irq with enable");
    @(negedge clk); irq_en = 0; probe(); chk("R9", irq, 0, "irq gated");
    cur_req = "R7"; pulse_clr(); probe(); chk("R7", {flag, ip}, 0, "cleared");

    cur_req = "R2";
    @(negedge clk); mode = 2'b10; msk = 8'h80; edg = 8'h90; pol = 8'h00; port_in = 8'h80;
    cyc(3); pulse_clr(); port_in = 8'h90; probe(); probe();
    chk("R2", flag, 1, "any-edge line");
    pulse_clr(); port_in = 8'h10; probe(); probe();
    chk("R4", flag, 1, "falling line in OR");

    cur_req = "R5";
    @(negedge clk); mode = 2'b11; msk = 8'hFF; edg = 0; pol = 8'hFF; port_in = 8'h24;
    probe(); probe(); chk("R5", vec, 5, "highest index");
    pulse_clr(); probe(); chk("R5", ip, 1, "ip held while match");
    @(negedge clk); port_in = 0; cyc(3); pulse_clr(); probe(); chk("R5", {flag, ip, vec}, 0, "match gone");

    cur_req = "R8";
    @(negedge clk); mode = 0; monly = 0; port_in = 8'h01; probe(); probe();
    chk("R6", flag, 0, "off mode flag");
    chk("R8", ip, 1, "change sets ip");
    @(negedge clk); monly = 1; cyc(2); pulse_clr(); port_in = 8'h03; probe(); probe();
    chk("R8", ip, 0, "match only ignores change");

    cur_req = "R10";
    @(negedge clk); mode = 2'b10; latched = 1; msk = 8'h01; edg = 8'h01; pol = 8'h01; port_in = 0;
    cyc(3); pulse_clr(); port_in = 8'h41; cyc(1); port_in = 8'hF0; probe(); probe(); probe();
    chk("R10", data_out, 8'h41, "frozen sample");
    pulse_clr(); probe(); chk("R10", data_out, 8'hF0, "released");
    cur_req = "R11";
    @(negedge clk); mode = 2'b11; msk = 8'hFF; pol = 8'hFF; edg = 0; probe(); probe();
    chk("R11", flag, 0, "latched level off");
    @(negedge clk); latched = 0;

    for (int s = 0; s < 60; s++) begin
      @(negedge clk);
      mode = $urandom; latched = $urandom; monly = $urandom; irq_en = $urandom;
      msk = $urandom & $urandom; edg = $urandom & $urandom; pol = $urandom;
      cur_req = (mode == 1) ? "R3" : (mode == 2) ? "R4" : (mode == 3) ? "R5" : "R6";
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if ($urandom_range(0, 2) == 0) port_in[$urandom_range(0, W-1)] ^= 1'b1;
        clr = ($urandom_range(0, 7) == 0);
      end
      clr = 0;
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule